// File: doc/BRIEF.md
# Serial presence byte store with write-protect control

This block holds a 256-byte, 8-bit-wide configuration store and decides which write requests may change it. The lower half of the address space (00h to 7Fh) can be locked against writes. The upper half (80h to FFh) can always be written. Two locks act on the lower half. The permanent lock can never be released once it is set. The reversible lock can be set and released, but only while a high-voltage-present qualifier input is asserted.

All traffic uses one request channel. Each cycle, `req_valid` with a 3-bit `req_op` carries one operation: a byte read, a byte write, or one of three protection commands. The outcome appears one clock after the request is taken. A read returns its byte on `rd_data` with `rd_valid`, or raises `rd_reject`. A write or command raises either `wr_accept` or `wr_reject` for one cycle. Every accepted write or command starts a programming period of `BUSY_CYCLES` clocks, and `busy` stays high for all of it. Any request that arrives during that period is turned away.

Top module: `spd_wp_ctrl`

## Requirements
- R1: A read (op 0) taken while not busy gives `rd_valid` high for one cycle in the next cycle, with `rd_data` equal to the last byte accepted at that address. This holds at every address, whatever the protection state.
- R2: A write (op 1) to an address with bit 7 set (80h to FFh) that is taken while not busy is always accepted. `wr_accept` is high for one cycle in the next cycle.
- R3: Every accepted write or protection command makes `busy` high for exactly `BUSY_CYCLES` consecutive cycles, starting with the cycle after the request is taken.
- R4: While `busy` is high, a read gives `rd_reject`, and a write or command gives `wr_reject`. Memory and protection state stay unchanged.
- R5: A write to an address with bit 7 clear (00h to 7Fh) while either lock is set gives `wr_reject` and leaves the byte unchanged.
- R6: Set-reversible (op 3) is accepted only when `hv_present` is high, the permanent lock is clear and the block is not busy. Otherwise it gives `wr_reject` and has no effect.
- R7: Clear-reversible (op 4) is accepted only when `hv_present` is high, the permanent lock is clear and the block is not busy. Once it is accepted, lower-half writes succeed again.
- R8: Set-permanent (op 2) is accepted when not busy and not already set. From then on, lower-half writes and all further protection commands are rejected.
- R9: After reset, `busy` and all response outputs are low. The locks start in the states given by `PRELOAD_PERM` and `PRELOAD_REV`, which default to unlocked.
- R10: Op codes 5, 6 and 7 are undefined. They give `wr_reject` and change nothing. In any cycle at most one of the four response outputs is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 3 | 0 read, 1 write, 2 set permanent, 3 set reversible, 4 clear reversible |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 8 | Write data |
| hv_present | input | 1 | High-voltage-present qualifier for the reversible lock |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 8 | Read data |
| rd_reject | output | 1 | Read refused (busy) |
| wr_accept | output | 1 | Write or command accepted |
| wr_reject | output | 1 | Write or command refused |
| busy | output | 1 | Programming period in progress |

## Verification
The assertions assume that `req_op` and `hv_present` are stable and known at the clock edge where a request is taken. They also assume that nothing outside this block changes the lock state. The reversible-lock check relies on `hv_present` at the edge where the lock changes. The bench therefore drives every input on the falling edge and holds it through the next rising edge. It changes `hv_present` only between requests. It issues lower-half reads only at addresses it has already written, so that every expected byte is known.

// File: rtl/spd_wp_pkg.sv
package spd_wp_pkg;

  typedef enum logic [2:0] {
    OP_READ     = 3'd0,
    OP_WRITE    = 3'd1,
    OP_SET_PERM = 3'd2,
    OP_SET_REV  = 3'd3,
    OP_CLR_REV  = 3'd4
  } spd_op_e;

  // outcome of one request, produced by the decision logic
  typedef struct packed {
    logic mem_we;
    logic set_perm;
    logic set_rev;
    logic clr_rev;
    logic start_busy;
    logic wr_ok;
    logic wr_bad;
    logic rd_ok;
    logic rd_bad;
  } spd_dec_t;

  typedef struct packed {
    logic wr_ok;
    logic wr_bad;
    logic rd_ok;
    logic rd_bad;
  } spd_resp_t;

endpackage

// File: rtl/spd_wp_decide.sv
module spd_wp_decide
  import spd_wp_pkg::*;
(
  input  logic       req_valid,
  input  logic [2:0] req_op,
  input  logic       addr_upper,
  input  logic       busy,
  input  logic       hv_present,
  input  logic       perm_lock,
  input  logic       rev_lock,
  output spd_dec_t   dec
);

  logic lower_locked;
  logic rev_cmd_ok;

  always_comb begin
    lower_locked = !addr_upper && (perm_lock || rev_lock);
    rev_cmd_ok   = hv_present && !perm_lock && !busy;
    dec          = '0;
    if (req_valid) begin
      case (req_op)
        OP_READ: begin
          dec.rd_ok  = !busy;
          dec.rd_bad = busy;
        end
        OP_WRITE: begin
          dec.mem_we = !busy && !lower_locked;
          dec.wr_ok  = dec.mem_we;
          dec.wr_bad = !dec.mem_we;
        end
        OP_SET_PERM: begin
          dec.set_perm = !busy && !perm_lock;
          dec.wr_ok    = dec.set_perm;
          dec.wr_bad   = !dec.set_perm;
        end
        OP_SET_REV: begin
          dec.set_rev = rev_cmd_ok;
          dec.wr_ok   = rev_cmd_ok;
          dec.wr_bad  = !rev_cmd_ok;
        end
        OP_CLR_REV: begin
          dec.clr_rev = rev_cmd_ok;
          dec.wr_ok   = rev_cmd_ok;
          dec.wr_bad  = !rev_cmd_ok;
        end
        default: dec.wr_bad = 1'b1;
      endcase
      dec.start_busy = dec.wr_ok;
    end
  end

endmodule

// File: rtl/spd_wp_state.sv
module spd_wp_state #(
  parameter bit PRELOAD_PERM = 1'b0,
  parameter bit PRELOAD_REV  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hv_present,
  input  logic set_perm,
  input  logic set_rev,
  input  logic clr_rev,
  output logic perm_lock,
  output logic rev_lock
);

  logic perm_d, perm_q;
  logic rev_d, rev_q;
  logic perm_en, rev_en;

  always_comb begin
    perm_en = set_perm;
    perm_d  = 1'b1;
    rev_en  = set_rev || clr_rev;
    rev_d   = set_rev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perm_q <= PRELOAD_PERM;
      rev_q  <= PRELOAD_REV;
    end else begin
      if (perm_en) perm_q <= perm_d;
      if (rev_en)  rev_q  <= rev_d;
    end
  end

  assign perm_lock = perm_q;
  assign rev_lock  = rev_q;

  // R8: the permanent lock never drops
  a_r8_perm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    perm_q |=> perm_q);

  // R8: once permanent, the reversible lock is frozen
  a_r8_rev_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    perm_q |=> $stable(rev_q));

  // R6 / R7: the reversible lock changes only with the qualifier present
  a_r6_rev_needs_hv: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rev_q) |-> $past(hv_present));

endmodule

// File: rtl/spd_wp_timer.sv
module spd_wp_timer #(
  parameter int BUSY_CYCLES = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             cnt_en;

  always_comb begin
    cnt_en = start || (cnt_q != '0);
    if (start) cnt_d = CNT_W'(BUSY_CYCLES);
    else       cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  // R3: a period, once started, runs down one step per cycle
  a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R4: no new period may start inside a running one
  a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);

endmodule

// File: rtl/spd_wp_store.sv
module spd_wp_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rd_q <= mem[addr];
  end

  assign rdata = rd_q;

  // R1: a port never reads and writes in the same cycle
  a_r1_port_exclusive: assert property (@(posedge clk) !(we && re));

endmodule

// File: rtl/spd_wp_ctrl.sv
module spd_wp_ctrl
  import spd_wp_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int BUSY_CYCLES  = 24,
  parameter bit PRELOAD_PERM = 1'b0,
  parameter bit PRELOAD_REV  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              hv_present,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_reject,
  output logic              wr_accept,
  output logic              wr_reject,
  output logic              busy
);

  localparam int TOP_BIT = ADDR_W - 1;

  spd_dec_t  dec;
  spd_resp_t resp_d, resp_q;
  logic      perm_lock, rev_lock;

  spd_wp_decide u_decide (
    .req_valid  (req_valid),
    .req_op     (req_op),
    .addr_upper (req_addr[TOP_BIT]),
    .busy       (busy),
    .hv_present (hv_present),
    .perm_lock  (perm_lock),
    .rev_lock   (rev_lock),
    .dec        (dec)
  );

  spd_wp_state #(
    .PRELOAD_PERM (PRELOAD_PERM),
    .PRELOAD_REV  (PRELOAD_REV)
  ) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .hv_present (hv_present),
    .set_perm   (dec.set_perm),
    .set_rev    (dec.set_rev),
    .clr_rev    (dec.clr_rev),
    .perm_lock  (perm_lock),
    .rev_lock   (rev_lock)
  );

  spd_wp_timer #(
    .BUSY_CYCLES (BUSY_CYCLES)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (dec.start_busy),
    .busy  (busy)
  );

  spd_wp_store #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_store (
    .clk   (clk),
    .we    (dec.mem_we),
    .re    (dec.rd_ok),
    .addr  (req_addr),
    .wdata (req_wdata),
    .rdata (rd_data)
  );

  always_comb begin
    resp_d.wr_ok  = dec.wr_ok;
    resp_d.wr_bad = dec.wr_bad;
    resp_d.rd_ok  = dec.rd_ok;
    resp_d.rd_bad = dec.rd_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resp_q <= '0;
    else        resp_q <= resp_d;
  end

  assign wr_accept = resp_q.wr_ok;
  assign wr_reject = resp_q.wr_bad;
  assign rd_valid  = resp_q.rd_ok;
  assign rd_reject = resp_q.rd_bad;

  // R3: an accepted write or command opens the busy period next cycle
  a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |-> busy);

  // R4: the store is never written while busy
  a_r4_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !dec.mem_we);

  // R5: a lower-half byte is written only with both locks clear
  a_r5_lower_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.mem_we && !req_addr[TOP_BIT]) |-> !(perm_lock || rev_lock));

  // R10: at most one response per cycle
  a_r10_single_response: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_accept, wr_reject, rd_valid, rd_reject}));

  // R1: read data appears only in answer to a read request
  a_r1_read_answers_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(req_valid && (req_op == 3'd0)));

endmodule

// File: tb/spd_wp_ctrl_test.sv
module spd_wp_ctrl_test;

  localparam int B = 24;

  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic [2:0] req_op;
  logic [7:0] req_addr;
  logic [7:0] req_wdata;
  logic       hv_present;
  logic       rd_valid, rd_reject, wr_accept, wr_reject, busy;
  logic [7:0] rd_data;

  int checks = 0;
  int fails  = 0;

  // expected item: [9:8] kind (0 accept, 1 reject, 2 read data, 3 read reject), [7:0] data
  logic [9:0] exp_q [$];
  string      tag_q [$];

  logic [7:0] m_mem [256];
  logic       m_perm, m_rev, m_acc;
  int         m_cnt;

  spd_wp_ctrl #(.BUSY_CYCLES(B)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .hv_present(hv_present),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_reject(rd_reject),
    .wr_accept(wr_accept), .wr_reject(wr_reject), .busy(busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // reference busy period
  always @(posedge clk) begin
    if (!rst_n)      m_cnt <= 0;
    else if (m_acc)  m_cnt <= B;
    else if (m_cnt > 0) m_cnt <= m_cnt - 1;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: compares responses and the busy flag one step after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n) begin
        check(busy == (m_cnt != 0), "R3", "busy", busy, m_cnt != 0);
        if (exp_q.size() > 0) begin
          logic [9:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({wr_accept, wr_reject, rd_valid, rd_reject} ==
                (4'b1000 >> e[9:8]), t, "response",
                {wr_accept, wr_reject, rd_valid, rd_reject}, 4'b1000 >> e[9:8]);
          if (e[9:8] == 2'd2)
            check(rd_data == e[7:0], t, "rd_data", rd_data, e[7:0]);
        end else begin
          check({wr_accept, wr_reject, rd_valid, rd_reject} == 4'b0000, "R10",
                "idle response", {wr_accept, wr_reject, rd_valid, rd_reject}, 0);
        end
      end
    end
  end

  // driver: computes the expected outcome and pushes it for the monitor
  task automatic issue(input logic [2:0] op, input logic [7:0] a,
                       input logic [7:0] d, input string tag);
    logic [1:0] kind;
    logic [7:0] data;
    bit         bsy;
    bsy  = (m_cnt != 0);
    kind = 2'd1;
    data = 8'h00;
    case (op)
      3'd0: begin
        kind = bsy ? 2'd3 : 2'd2;
        data = m_mem[a];
      end
      3'd1: if (!bsy && !(a < 8'h80 && (m_perm || m_rev))) begin
        kind = 2'd0; m_mem[a] = d;
      end
      3'd2: if (!bsy && !m_perm) begin
        kind = 2'd0; m_perm = 1'b1;
      end
      3'd3: if (!bsy && !m_perm && hv_present) begin
        kind = 2'd0; m_rev = 1'b1;
      end
      3'd4: if (!bsy && !m_perm && hv_present) begin
        kind = 2'd0; m_rev = 1'b0;
      end
      default: kind = 2'd1;
    endcase
    exp_q.push_back({kind, data});
    tag_q.push_back(tag);
    req_valid = 1'b1;
    req_op    = op;
    req_addr  = a;
    req_wdata = d;
    m_acc     = (kind == 2'd0);
    @(negedge clk);
    req_valid = 1'b0;
    m_acc     = 1'b0;
  endtask

  task automatic settle();
    while (m_cnt != 0 || exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 3'd0; req_addr = 8'h00;
    req_wdata = 8'h00; hv_present = 1'b0;
    m_perm = 1'b0; m_rev = 1'b0; m_acc = 1'b0;
    repeat (4) @(negedge clk);
    // R9: reset state
    check({busy, wr_accept, wr_reject, rd_valid, rd_reject} == 5'b0, "R9",
          "reset outputs", {busy, wr_accept, wr_reject, rd_valid, rd_reject}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R3: lower and upper writes while unlocked, then read back (R1)
    issue(3'd1, 8'h10, 8'hA5, "R3");  settle();
    issue(3'd1, 8'h90, 8'h3C, "R2");  settle();
    issue(3'd1, 8'h7F, 8'h5A, "R3");  settle();
    issue(3'd0, 8'h10, 8'h00, "R1");
    issue(3'd0, 8'h90, 8'h00, "R1");
    issue(3'd0, 8'h7F, 8'h00, "R1");  settle();

    // R4: requests during the busy period
    issue(3'd1, 8'hC0, 8'h11, "R2");
    issue(3'd1, 8'h10, 8'hEE, "R4");
    issue(3'd0, 8'h10, 8'h00, "R4");
    issue(3'd3, 8'h00, 8'h00, "R4");
    settle();
    issue(3'd0, 8'h10, 8'h00, "R4");
    issue(3'd0, 8'hC0, 8'h00, "R4");  settle();

    // R6: reversible lock without then with the qualifier
    issue(3'd3, 8'h00, 8'h00, "R6");  settle();
    issue(3'd1, 8'h10, 8'h01, "R6");  settle();
    hv_present = 1'b1;
    issue(3'd3, 8'h00, 8'h00, "R6");  settle();
    hv_present = 1'b0;
    // R5: lower half now locked, upper half still open
    issue(3'd1, 8'h10, 8'h77, "R5");
    issue(3'd1, 8'h00, 8'h77, "R5");  settle();
    issue(3'd0, 8'h10, 8'h00, "R5");
    issue(3'd1, 8'hA0, 8'h42, "R2");  settle();
    issue(3'd0, 8'hA0, 8'h00, "R1");  settle();

    // R7: clear needs the qualifier
    issue(3'd4, 8'h00, 8'h00, "R7");  settle();
    issue(3'd1, 8'h10, 8'h66, "R7");  settle();
    hv_present = 1'b1;
    issue(3'd4, 8'h00, 8'h00, "R7");  settle();
    hv_present = 1'b0;
    issue(3'd1, 8'h10, 8'h66, "R7");  settle();
    issue(3'd0, 8'h10, 8'h00, "R7");  settle();

    // R10: undefined op codes
    issue(3'd5, 8'h20, 8'h00, "R10");
    issue(3'd6, 8'h20, 8'h00, "R10");
    issue(3'd7, 8'h20, 8'h00, "R10"); settle();
    issue(3'd0, 8'h7F, 8'h00, "R10"); settle();

    // R8: permanent lock
    issue(3'd2, 8'h00, 8'h00, "R8");  settle();
    issue(3'd1, 8'h10, 8'h99, "R8");  settle();
    hv_present = 1'b1;
    issue(3'd4, 8'h00, 8'h00, "R8");  settle();
    issue(3'd3, 8'h00, 8'h00, "R8");  settle();
    issue(3'd1, 8'h7F, 8'h99, "R8");  settle();
    hv_present = 1'b0;
    issue(3'd2, 8'h00, 8'h00, "R8");  settle();
    issue(3'd1, 8'hFF, 8'hCD, "R8");  settle();
    issue(3'd0, 8'h10, 8'h00, "R8");
    issue(3'd0, 8'hFF, 8'h00, "R8");  settle();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule